// File: doc/BRIEF.md
# Ring-Capable Boundary Wrapper Chain

This block is a chain of boundary cells placed around a core. There are `N_IN` input-side cells followed by `N_OUT` output-side cells. In functional mode the pin and core signals pass straight through, and a serial shift stage per cell forms an ordinary scan path. Each cell also owns one configuration bit, held in a shadow stage that loads from the shift stage on an update strobe.

When the global ring-test input `osc_en` is raised, the chain becomes a purely combinational path that an interconnect loop can run through. An input cell passes either the upstream chain signal or its own pin onto the chain, as its configuration bit selects. An output cell passes the upstream signal, inverted if its configuration bit is set, both downstream and onto its pin. Because the path holds no flop, a loop closed through the wires and this chain oscillates at a rate set by the wire and cell delays.

A status output tells whether the configured number of inversions is even. With an even count, a loop built through the chain cannot sustain oscillation.

Top module: `osc_wrap_chain`

## Requirements
- R1: After reset every shift and shadow bit is 0. With `osc_en`=1, `scan_out` equals `scan_in`, every `pin_out` bit equals `scan_in`, and `inv_even`=1.
- R2: While `osc_en`=0, `pin_out` equals `core_out` and `core_in` equals `pin_in`. `core_in` equals `pin_in` in every mode.
- R3: While `shift_en`=1, each rising clock edge moves the shift stage one cell along the chain and takes `scan_in` into cell 0. While `osc_en`=0, `scan_out` shows the shift stage of cell `N_IN+N_OUT-1`, so a bit appears there `N_IN+N_OUT-1` edges after the edge that took it in. While `shift_en`=0 the shift stage holds.
- R4: While `osc_en`=0, `update_en`=1 at a rising edge copies the whole shift stage into the shadow stage. Chain positions 0..`N_IN`-1 are the input cells' select bits. Positions `N_IN`..`N_IN+N_OUT`-1 are the output cells' inversion bits.
- R5: With `osc_en`=1, input cell i forwards `pin_in[i]` when its select bit is 1, and the upstream chain signal when it is 0. Cell 0's upstream signal is `scan_in`.
- R6: With `osc_en`=1, output cell j drives the upstream chain signal XOR its inversion bit both to `pin_out[j]` and downstream. The last cell's downstream signal is `scan_out`.
- R7: With `osc_en`=1, `scan_out` and `pin_out` follow `scan_in` and `pin_in` with no clock edge in between.
- R8: Shifting while `osc_en`=1 leaves the ring path unchanged.
- R9: `update_en` has no effect while `osc_en`=1.
- R10: `inv_even` is 1 exactly when the number of output-cell inversion bits set in the shadow stage is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the shift and shadow stages |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Shift the chain by one cell per clock |
| update_en | input | 1 | Copy the shift stage into the shadow stage |
| osc_en | input | 1 | Global ring-test mode |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output; end of the ring path in test mode |
| pin_in | input | N_IN | Pin-side inputs |
| core_in | output | N_IN | Core-side copies of the pin inputs |
| core_out | input | N_OUT | Core-side outputs |
| pin_out | output | N_OUT | Pin-side outputs |
| inv_even | output | 1 | Even count of configured inversions |

## Verification
A wrong shift-stage bit shows on `scan_out` as soon as it reaches the last cell. A wrong shadow bit shows only once ring mode is entered, and then within the same cycle, as a wrong level on `scan_out`, on one or more `pin_out` bits and possibly on `inv_even`. To expose any such bit, every one of the 2^(N_IN+N_OUT) configurations of the default build is loaded and the ring is driven with every combination of `scan_in` and `pin_in`. In functional mode, a stale shadow bit or a leaking update is caught the moment ring mode is re-entered.

// File: rtl/osc_wrap_pkg.sv
package osc_wrap_pkg;
    typedef enum logic {
        MODE_FUNC = 1'b0,
        MODE_RING = 1'b1
    } wrap_mode_e;
endpackage

// File: rtl/osc_wrap_cfg.sv
module osc_wrap_cfg #(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           update_en,
    input  logic           ring_mode,
    input  logic           ser_in,
    output logic [LEN-1:0] stage_q,
    output logic [LEN-1:0] shadow_q
);
    typedef struct packed {
        logic [LEN-1:0] stage;
        logic [LEN-1:0] shadow;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.stage = {st_q.stage[LEN-2:0], ser_in};
        end
        // The shadow stage is frozen while a ring is live
        if (update_en && !ring_mode) begin
            st_d.shadow = st_q.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_q  = st_q.stage;
    assign shadow_q = st_q.shadow;
endmodule

// File: rtl/osc_in_cell.sv
module osc_in_cell (
    input  logic ring_mode,
    input  logic sel,
    input  logic up,
    input  logic stage,
    input  logic pin_i,
    output logic down,
    output logic core_o
);
    // Fixed non-inverting buffer on the ring path
    always_comb begin
        core_o = pin_i;
        if (ring_mode) begin
            down = sel ? pin_i : up;
        end else begin
            down = stage;
        end
    end
endmodule

// File: rtl/osc_out_cell.sv
module osc_out_cell (
    input  logic ring_mode,
    input  logic inv,
    input  logic up,
    input  logic stage,
    input  logic core_i,
    output logic down,
    output logic pin_o
);
    logic ring_val;

    always_comb begin
        ring_val = up ^ inv;
        if (ring_mode) begin
            down  = ring_val;
            pin_o = ring_val;
        end else begin
            down  = stage;
            pin_o = core_i;
        end
    end
endmodule

// File: rtl/osc_wrap_chain.sv
module osc_wrap_chain
    import osc_wrap_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             osc_en,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pin_out,
    output logic             inv_even
);
    localparam int LEN = N_IN + N_OUT;

    wrap_mode_e     mode;
    logic [LEN-1:0] shift_q;
    logic [LEN-1:0] shadow_q;
    logic [LEN:0]   seg;

    assign mode   = osc_en ? MODE_RING : MODE_FUNC;
    assign seg[0] = scan_in;

    osc_wrap_cfg #(.LEN(LEN)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .update_en (update_en),
        .ring_mode (mode == MODE_RING),
        .ser_in    (scan_in),
        .stage_q   (shift_q),
        .shadow_q  (shadow_q)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        osc_in_cell u_cell (
            .ring_mode (mode == MODE_RING),
            .sel       (shadow_q[i]),
            .up        (seg[i]),
            .stage     (shift_q[i]),
            .pin_i     (pin_in[i]),
            .down      (seg[i+1]),
            .core_o    (core_in[i])
        );
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        osc_out_cell u_cell (
            .ring_mode (mode == MODE_RING),
            .inv       (shadow_q[N_IN+j]),
            .up        (seg[N_IN+j]),
            .stage     (shift_q[N_IN+j]),
            .core_i    (core_out[j]),
            .down      (seg[N_IN+j+1]),
            .pin_o     (pin_out[j])
        );
    end

    assign scan_out = seg[LEN];
    assign inv_even = ~^shadow_q[LEN-1:N_IN];
endmodule

// File: rtl/osc_wrap_chk.sv
module osc_wrap_chk #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    shift_en,
    input logic                    update_en,
    input logic                    osc_en,
    input logic                    scan_in,
    input logic [N_OUT-1:0]        core_out,
    input logic [N_OUT-1:0]        pin_out,
    input logic [N_IN+N_OUT-1:0]   shift_q,
    input logic [N_IN+N_OUT-1:0]   shadow_q
);
    a_r2_func_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> pin_out == core_out);

    a_r3_shift_take: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> shift_q[0] == $past(scan_in));

    a_r3_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> shift_q == $past(shift_q));

    a_r4_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (update_en && !osc_en) |=> shadow_q == $past(shift_q));

    a_r9_ring_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en |=> shadow_q == $past(shadow_q));
endmodule

bind osc_wrap_chain osc_wrap_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .update_en (update_en),
    .osc_en    (osc_en),
    .scan_in   (scan_in),
    .core_out  (core_out),
    .pin_out   (pin_out),
    .shift_q   (shift_q),
    .shadow_q  (shadow_q)
);

// File: tb/tb_osc_wrap_chain.sv
module tb_osc_wrap_chain;
    localparam int NI = 4;
    localparam int NO = 4;
    localparam int L  = NI + NO;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          shift_en = 1'b0;
    logic          update_en = 1'b0;
    logic          osc_en = 1'b0;
    logic          scan_in = 1'b0;
    logic          scan_out;
    logic [NI-1:0] pin_in = '0;
    logic [NI-1:0] core_in;
    logic [NO-1:0] core_out = '0;
    logic [NO-1:0] pin_out;
    logic          inv_even;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    osc_wrap_chain #(.N_IN(NI), .N_OUT(NO)) dut (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .update_en(update_en),
        .osc_en(osc_en), .scan_in(scan_in), .scan_out(scan_out),
        .pin_in(pin_in), .core_in(core_in), .core_out(core_out),
        .pin_out(pin_out), .inv_even(inv_even)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected ring outputs from R5/R6: walk the chain from scan_in
    task automatic ring_model(input logic [L-1:0] c, input logic si, input logic [NI-1:0] pins,
                              output logic [NO-1:0] pexp, output logic soexp);
        logic v;
        v = si;
        for (int i = 0; i < NI; i++) if (c[i]) v = pins[i];
        for (int j = 0; j < NO; j++) begin
            v = v ^ c[NI+j];
            pexp[j] = v;
        end
        soexp = v;
    endtask

    task automatic shift_word(input logic [L-1:0] c);
        for (int k = L-1; k >= 0; k--) begin
            @(negedge clk);
            shift_en = 1'b1;
            scan_in  = c[k];
        end
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    task automatic pulse_update();
        update_en = 1'b1;
        @(negedge clk);
        update_en = 1'b0;
    endtask

    task automatic check_ring(input string req, input logic [L-1:0] c);
        logic [NO-1:0] pe;
        logic          se;
        for (int s = 0; s < 32; s++) begin
            scan_in = s[0];
            pin_in  = s[4:1];
            #1;
            ring_model(c, s[0], s[4:1], pe, se);
            check({req, " scan_out"}, {31'd0, scan_out}, {31'd0, se});
            check({req, " pin_out"}, {28'd0, pin_out}, {28'd0, pe});
        end
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [19:0] pat;
        logic [L-1:0] cfg_a;
        int ones;

        // R1: reset state
        osc_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int b = 0; b < 2; b++) begin
            scan_in = b[0];
            #1;
            check("R1 scan_out", {31'd0, scan_out}, b);
            check("R1 pin_out", {28'd0, pin_out}, b[0] ? 32'hF : 32'h0);
        end
        check("R1 inv_even", {31'd0, inv_even}, 1);
        osc_en = 1'b0;

        // R3: serial shift-through and hold
        pat = 20'hB5A3C;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (t >= L) check("R3 shift delay", {31'd0, scan_out}, {31'd0, pat[t-L]});
            shift_en = 1'b1;
            scan_in  = pat[t];
        end
        @(negedge clk);
        shift_en = 1'b0;
        check("R3 shift last", {31'd0, scan_out}, {31'd0, pat[20-L]});
        repeat (3) begin
            scan_in = ~scan_in;
            @(negedge clk);
            check("R3 hold", {31'd0, scan_out}, {31'd0, pat[20-L]});
        end

        // Exhaustive sweep over every configuration: R2 R4 R5 R6 R7 R10
        for (int cfg = 0; cfg < (1 << L); cfg++) begin
            shift_word(cfg[L-1:0]);
            pulse_update();
            core_out = cfg[3:0] ^ 4'h9;
            pin_in   = ~cfg[7:4];
            #1;
            check("R2 pin_out", {28'd0, pin_out}, {28'd0, cfg[3:0] ^ 4'h9});
            check("R2 core_in", {28'd0, core_in}, {28'd0, ~cfg[7:4]});
            check("R3 scan_out last cell", {31'd0, scan_out}, {31'd0, cfg[L-1]});
            osc_en = 1'b1;
            check_ring("R4 R5 R6 R7 ring", cfg[L-1:0]);
            check("R2 core_in ring", {28'd0, core_in}, {28'd0, pin_in});
            ones = 0;
            for (int j = 0; j < NO; j++) ones += int'(cfg[NI+j]);
            check("R10 inv_even", {31'd0, inv_even}, {31'd0, ~ones[0]});
            @(negedge clk);
            osc_en = 1'b0;
        end

        // R8 and R9: shifting and updating while the ring is live
        cfg_a = 8'b1011_0110;
        shift_word(cfg_a);
        pulse_update();
        osc_en = 1'b1;
        shift_word(~cfg_a);
        check_ring("R8 shift in ring", cfg_a);
        @(negedge clk);
        pulse_update();
        check_ring("R9 update in ring", cfg_a);
        check("R9 inv_even", {31'd0, inv_even}, 0);
        osc_en = 1'b0;
        @(negedge clk);
        pulse_update();
        osc_en = 1'b1;
        check_ring("R4 update after ring", ~cfg_a);
        check("R10 inv_even new", {31'd0, inv_even}, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule